// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for a four-beat burst over a start address of parameterized width. A one-cycle start pulse captures a full external address and the ordering choice. After that, each cycle with the advance input high steps to the next beat, and each cycle with advance low keeps the current beat. Only the two least-significant address bits move. They follow either a linear order, which counts upward modulo four from the starting offset, or an interleaved order, which is the starting offset XOR the beat count. After the fourth beat the sequence wraps back to the start address.

A memory controller sits in front of it. The controller raises start with the address it issued and raises advance once per completed beat. It uses the address output, and the beat index output when it needs to know its position in the burst. The ordering input is read only at load time. A change on that input partway through a burst therefore has no effect until the next start. Upper address bits keep the value they were loaded with until the next start.

Top module: `bam_burst_addr_gen`

## Requirements
- R1: While rst_n is low at a rising edge, addr_o and beat_o become all zeros.
- R2: A start_i high at a rising edge loads addr_i, so that addr_o equals addr_i and beat_o equals 0 after that edge.
- R3: When start_i and adv_i are high together, the load of R2 happens and no advance takes place.
- R4: With start_i low and adv_i high, beat_o increments by one modulo 4 at the edge.
- R5: With start_i and adv_i both low, addr_o and beat_o keep their values.
- R6: When interleave_i was 0 at load, addr_o[1:0] equals (start offset + beat_o) modulo 4. For example, start offset 01 gives 01, 10, 11, 00.
- R7: When interleave_i was 1 at load, addr_o[1:0] equals start offset XOR beat_o. For example, start offset 01 gives 01, 00, 11, 10, and start offset 10 gives 10, 11, 00, 01.
- R8: interleave_i is read only on a load edge. Changing it while start_i is low leaves the sequence order unchanged.
- R9: addr_o bits above bit 1 always equal the address last loaded.
- R10: Four advances after a load bring addr_o back to the loaded address and beat_o back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Burst start: load addr_i and interleave_i |
| adv_i | input | 1 | Step to the next beat |
| interleave_i | input | 1 | 1 selects interleaved order, 0 selects linear order; default is interleaved if left tied high |
| addr_i | input | AW | External start address |
| addr_o | output | AW | Current burst address |
| beat_o | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
The bench walks both orderings from every starting offset. An adder used in interleaved mode, or XOR used in linear mode, shows up at once on offsets 01 and 11. It raises start and advance together: a design that lets advance win would report beat 1 instead of 0. It flips the ordering input partway through a burst, which exposes a design that decodes the live input rather than the captured one. It also loads addresses with all upper bits set and runs through the wrap. A carry leaking out of the low two bits, or a counter that does not wrap, would then corrupt the upper address or miss the return to the start.

// File: rtl/bam_pkg.sv
// Shared constants and types for the burst address sequencer.
// Assumes a fixed four-beat burst, so the offset and beat fields are two bits.
package bam_pkg;
    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bam_beat_ctr.sv
// Beat counter: cleared by reset and by a load, stepped by advance.
// Assumes load has priority over step; the count wraps modulo 4 naturally.
module bam_beat_ctr
    import bam_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  logic  step_i,
    output beat_t beat_o
);
    beat_t beat_q;

    // Purpose: clear on reset or load, else step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load_i) begin
            beat_q <= '0;
        end else if (step_i) begin
            beat_q <= beat_q + beat_t'(1);
        end
    end

    assign beat_o = beat_q;
endmodule

// File: rtl/bam_start_reg.sv
// Start register: captures the full start address and the ordering on load.
// Assumes the captured values are held until the next load.
module bam_start_reg
    import bam_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic          interleave_i,
    output logic [AW-1:0] base_o,
    output order_e        order_o
);
    logic [AW-1:0] base_q;
    order_e        order_q;

    // Purpose: capture address and ordering on load; zero address on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (load_i) begin
            base_q  <= addr_i;
            order_q <= interleave_i ? ORD_INTERLEAVE : ORD_LINEAR;
        end
    end

    assign base_o  = base_q;
    assign order_o = order_q;
endmodule

// File: rtl/bam_offset_map.sv
// Offset map: combines the start offset and the beat count into the low address bits.
// Purely combinational; the order is chosen by the captured mode.
module bam_offset_map
    import bam_pkg::*;
(
    input  beat_t  start_ofs_i,
    input  beat_t  beat_i,
    input  order_e order_i,
    output beat_t  ofs_o
);
    // Purpose: select a modulo-4 sum or an XOR of offset and beat.
    always_comb begin
        unique case (order_i)
            ORD_LINEAR:     ofs_o = start_ofs_i + beat_i;
            ORD_INTERLEAVE: ofs_o = start_ofs_i ^ beat_i;
            default:        ofs_o = start_ofs_i;
        endcase
    end
endmodule

// File: rtl/bam_burst_addr_gen.sv
// Top: four-beat burst address sequencer.
// Upper address bits come straight from the start register, and the low two bits
// come from the offset map. Assumes AW >= 3.
module bam_burst_addr_gen
    import bam_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          adv_i,
    input  logic          interleave_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o,
    output logic [1:0]    beat_o
);
    localparam int UPPER_W = AW - BEAT_W;

    logic [AW-1:0] base;
    order_e        order;
    beat_t         beat;
    beat_t         low_ofs;

    bam_start_reg #(.AW(AW)) u_start (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (start_i),
        .addr_i       (addr_i),
        .interleave_i (interleave_i),
        .base_o       (base),
        .order_o      (order)
    );

    bam_beat_ctr u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_i),
        .step_i (adv_i),
        .beat_o (beat)
    );

    bam_offset_map u_map (
        .start_ofs_i (base[BEAT_W-1:0]),
        .beat_i      (beat),
        .order_i     (order),
        .ofs_o       (low_ofs)
    );

    generate
        if (UPPER_W > 0) begin : g_upper
            assign addr_o = {base[AW-1:BEAT_W], low_ofs};
        end else begin : g_narrow
            assign addr_o = low_ofs;
        end
    endgenerate

    assign beat_o = beat;
endmodule

// File: rtl/bam_burst_addr_chk.sv
// Checker for the burst address sequencer, relating its ports across cycles.
module bam_burst_addr_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          adv_i,
    input logic [AW-1:0] addr_i,
    input logic [AW-1:0] addr_o,
    input logic [1:0]    beat_o
);
    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (addr_o == $past(addr_i)) && (beat_o == 2'd0)); // R2

    AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && adv_i) |=> (beat_o == 2'd0)); // R3

    AST_STEP_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && adv_i) |=> (beat_o == $past(beat_o) + 2'd1)); // R4

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !adv_i) |=> ($stable(addr_o) && $stable(beat_o))); // R5

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(addr_o[AW-1:2])); // R9
endmodule

bind bam_burst_addr_gen bam_burst_addr_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .adv_i   (adv_i),
    .addr_i  (addr_i),
    .addr_o  (addr_o),
    .beat_o  (beat_o)
);

// File: tb/tb_bam_burst_addr_gen.sv
module tb_bam_burst_addr_gen;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          adv_i = 1'b0;
    logic          interleave_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;

    int checks = 0;
    int errors = 0;

    // model state
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    logic          m_il   = 1'b1;

    bam_burst_addr_gen #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_i(adv_i),
        .interleave_i(interleave_i), .addr_i(addr_i),
        .addr_o(addr_o), .beat_o(beat_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = m_il ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check(input string req);
        checks++;
        if (addr_o !== exp_addr() || beat_o !== m_beat) begin
            errors++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, addr_o, beat_o, exp_addr(), m_beat);
        end
    endtask

    // one clock: drive at negedge, update model, sample 2 ns after the edge
    task automatic cycle(input logic st, input logic av, input logic il,
                         input logic [AW-1:0] a);
        @(negedge clk);
        start_i = st; adv_i = av; interleave_i = il; addr_i = a;
        @(posedge clk);
        if (st) begin
            m_base = a; m_beat = 2'd0; m_il = il;
        end else if (av) begin
            m_beat = m_beat + 2'd1;
        end
        #2;
    endtask

    task automatic t_reset();
        cycle(1'b1, 1'b0, 1'b1, 17'h1ABCD);
        @(negedge clk); rst_n = 1'b0; start_i = 1'b0;
        @(posedge clk); #2;
        m_base = '0; m_beat = '0; m_il = 1'b1;
        check("R1");
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_order(input logic il, input logic [1:0] ofs, input string req);
        logic [AW-1:0] a;
        a = {15'h5A5A, ofs};
        cycle(1'b1, 1'b0, il, a);
        check("R2");
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, 1'b1, il, 17'h0);
            check(req);
        end
        cycle(1'b0, 1'b1, il, 17'h0);
        check("R10");
        checks++;
        if (addr_o !== a) begin
            errors++;
            $display("FAIL R10: addr=%h expected=%h", addr_o, a);
        end
    endtask

    task automatic t_hold();
        cycle(1'b1, 1'b0, 1'b0, 17'h00021);
        cycle(1'b0, 1'b1, 1'b0, 17'h0);
        cycle(1'b0, 1'b0, 1'b0, 17'h1FFFF);
        check("R5");
        cycle(1'b0, 1'b0, 1'b1, 17'h0);
        check("R5");
    endtask

    task automatic t_precedence();
        cycle(1'b1, 1'b0, 1'b1, 17'h00003);
        cycle(1'b0, 1'b1, 1'b1, 17'h0);
        cycle(1'b1, 1'b1, 1'b1, 17'h00106);
        check("R3");
        cycle(1'b0, 1'b1, 1'b1, 17'h0);
        check("R4");
    endtask

    task automatic t_mode_held();
        cycle(1'b1, 1'b0, 1'b1, 17'h00001);
        cycle(1'b0, 1'b1, 1'b0, 17'h0);  // flip input mid-burst
        check("R8");
        cycle(1'b0, 1'b1, 1'b0, 17'h0);
        check("R8");
        cycle(1'b1, 1'b0, 1'b0, 17'h00003);
        cycle(1'b0, 1'b1, 1'b1, 17'h0);
        check("R8");
    endtask

    task automatic t_upper();
        cycle(1'b1, 1'b0, 1'b0, 17'h1FFFF);
        for (int i = 0; i < 6; i++) begin
            cycle(1'b0, 1'b1, 1'b0, 17'h0);
            check("R9");
            checks++;
            if (addr_o[AW-1:2] !== 15'h7FFF) begin
                errors++;
                $display("FAIL R9: upper=%h expected=7fff", addr_o[AW-1:2]);
            end
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #2;
        check("R1");
        @(negedge clk); rst_n = 1'b1;
        for (int o = 0; o < 4; o++) t_order(1'b0, 2'(o), "R6");
        for (int o = 0; o < 4; o++) t_order(1'b1, 2'(o), "R7");
        t_hold();
        t_precedence();
        t_mode_held();
        t_upper();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule